// File: doc/BRIEF.md
# Ones-Ordered Shift-Accumulate Multiplier

This block multiplies two unsigned N-bit operands over several clock cycles. After a start request it counts the set bits in both operands. The operand with fewer ones becomes the multiplier. The other operand becomes the multiplicand. When both counts are equal, the first operand stays the multiplicand.

Each working cycle picks the highest set bit still left in the multiplier. The multiplicand is shifted left by that bit's position in one cycle and added into a 2N-bit accumulator, and the bit is then cleared. The operation ends when the multiplier has no bits left. Latency therefore depends on the data: one counting cycle plus one cycle for each set bit of the chosen multiplier.

A client raises `start` with both operands while `busy` is low. It then waits for the one-cycle `done` pulse and reads `product`.

Top module: `pc_shift_mul`

## Requirements
- R1: When `done` is high, `product` equals the full unsigned 2N-bit product of the two operands that were accepted.
- R2: A `start` sampled high at a clock edge while `busy` is low is accepted. The operands are captured at that edge, and `busy` is high in the following cycle.
- R3: `done` is first high exactly 1 + min(ones(a), ones(b)) clock edges after the edge that accepted the operation. When the counts are equal, the latency is 1 + that count.
- R4: If either operand is zero, `done` rises one edge after acceptance and `product` is zero.
- R5: A `start` sampled while `busy` is high is ignored. The running operation's product and latency are unchanged.
- R6: `done` is high for exactly one cycle per operation, and `busy` is low whenever `done` is high.
- R7: While idle with no new accepted start, `product` holds the last result.
- R8: After reset, `busy` and `done` are low and `product` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; accepted only while busy is low |
| a | input | N | First operand (kept as multiplicand on a ones-count tie) |
| b | input | N | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when product is valid |
| product | output | 2N | Unsigned product |

## Verification
If the operand selection is wrong, the product can still be correct, but the latency is wrong. The completion edge then moves to 1 + the larger ones count, so the check shows it on the very first operation whose two counts differ. A wrong priority encoder, or a term bit that is not cleared, corrupts the product or stalls completion. The error appears at the first `done` of an affected operand pair. Faults in the accept path show up one cycle after `start`, in `busy`, or as a changed result when `start` is driven while the block is busy.

// File: rtl/pc_shift_mul.sv
`timescale 1ns/1ps
module pc_shift_mul #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  localparam int CW = $clog2(N + 1);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_COUNT, S_RUN} state_t;

  state_t         state;
  logic [N-1:0]   mcand, mrem, mrem_next;
  logic [2*N-1:0] acc, term;
  logic [CW-1:0]  ones_c, ones_r;
  logic [IW-1:0]  top_idx;
  logic           done_q;

  function automatic logic [CW-1:0] ones(input logic [N-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++) s = s + CW'(v[i]);
    return s;
  endfunction

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < N; i++)
      if (mrem[i]) top_idx = IW'(i);
  end

  assign ones_c    = ones(mcand);
  assign ones_r    = ones(mrem);
  assign term      = {{N{1'b0}}, mcand} << top_idx;
  assign mrem_next = mrem & ~(N'(1) << top_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mcand  <= '0;
      mrem   <= '0;
      acc    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mcand <= a;
          mrem  <= b;
          acc   <= '0;
          state <= S_COUNT;
        end
        S_COUNT: begin
          if (ones_c < ones_r) begin
            mcand <= mrem;
            mrem  <= mcand;
          end
          if (ones_c == '0 || ones_r == '0) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            state <= S_RUN;
          end
        end
        S_RUN: begin
          acc  <= acc + term;
          mrem <= mrem_next;
          if (mrem_next == '0) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = done_q;
  assign product = acc;
endmodule

// File: rtl/pc_shift_mul_chk.sv
`timescale 1ns/1ps
module pc_shift_mul_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

bind pc_shift_mul pc_shift_mul_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/tb_pc_shift_mul.sv
`timescale 1ns/1ps
module tb_pc_shift_mul;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   a = '0, b = '0;
  logic           busy, done;
  logic [2*N-1:0] product;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pc_shift_mul #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .busy(busy), .done(done), .product(product)
  );

  // {a, b, product, latency}
  localparam int NV = 10;
  localparam logic [39:0] VEC [NV] = '{
    {8'd11,  8'd9,   16'd99,    8'd3},
    {8'd9,   8'd11,  16'd99,    8'd3},
    {8'd0,   8'd200, 16'd0,     8'd1},
    {8'd0,   8'd0,   16'd0,     8'd1},
    {8'd255, 8'd255, 16'd65025, 8'd9},
    {8'd128, 8'd1,   16'd128,   8'd2},
    {8'd255, 8'd1,   16'd255,   8'd2},
    {8'd1,   8'd255, 16'd255,   8'd2},
    {8'd170, 8'd85,  16'd14450, 8'd5},
    {8'd7,   8'd8,   16'd56,    8'd2}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [N-1:0] xa, input logic [N-1:0] xb,
                        input int exp_p, input int exp_lat, input bit poke);
    int n;
    @(negedge clk);
    start = 1'b1; a = xa; b = xb;
    @(posedge clk); #1;
    check(busy === 1'b1, "R2 busy after accept", busy, 1);
    @(negedge clk);
    start = poke; a = ~xa; b = xb ^ 8'h5A;
    n = 1;
    while (done !== 1'b1 && n < 64) begin
      @(posedge clk); #1;
      if (done !== 1'b1) n++;
    end
    if (n == 1) begin
      @(negedge clk);
    end
    start = 1'b0;
    check(n == exp_lat, (poke ? "R5 latency with start while busy" : "R3 latency"), n, exp_lat);
    check(product == 16'(exp_p), (exp_p == 0 ? "R4 zero product" : (poke ? "R5 product with start while busy" : "R1 product")), product, exp_p);
    check(busy === 1'b0, "R6 busy low with done", busy, 0);
    @(posedge clk); #1;
    check(done === 1'b0, "R6 done one cycle", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1;
    check(busy === 1'b0 && done === 1'b0, "R8 reset outputs", {busy, done}, 0);
    check(product === '0, "R8 reset product", product, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][39:32], VEC[i][31:24], int'(VEC[i][23:8]), int'(VEC[i][7:0]), 1'b0);

    for (int x = 0; x < 256; x += 17)
      for (int y = 0; y < 256; y += 13) begin
        int c;
        c = $countones(x[7:0]) < $countones(y[7:0]) ? $countones(x[7:0]) : $countones(y[7:0]);
        run_op(x[7:0], y[7:0], x * y, 1 + c, 1'b0);
      end

    // R5: new start while busy must be ignored
    run_op(8'd255, 8'd255, 65025, 9, 1'b1);
    run_op(8'd13, 8'd0, 0, 1, 1'b1);

    // R7: product holds while idle
    repeat (6) @(posedge clk);
    #1;
    check(product == 16'd0 && busy === 1'b0, "R7 product hold idle", product, 0);
    run_op(8'd200, 8'd3, 600, 3, 1'b0);
    repeat (5) @(posedge clk);
    #1;
    check(product == 16'd600 && done === 1'b0, "R7 product hold after done", product, 600);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule